// File: doc/BRIEF.md
# Stereo Pulse-Width Audio Channel Router

This block turns a buffer of left and right pulse-width audio samples into a run of stereo output samples that has a different length. A 4-bit mode field picks the routing. One code passes the channels straight through and one swaps them. A set of mono codes takes one source channel and sends it to one or both outputs. Four codes are invalid and produce no contribution. Each routed sample is added, with signed saturation, to an accumulator value that the consumer presents for the same output slot. The result is mixed into a buffer that already holds other audio.

A run starts with a pulse on `start`, together with the source length and the output length. The block first works out a 16.16 fixed-point step, which is the source length divided by the output length, using a sequential restoring divider. It then emits one output sample per cycle. It keeps a phase accumulator that adds the step for each output. The integer carry moves the read pointer and the fraction is kept for the next output. The read pointer `rdIdx` and the output slot `outIdx` are driven out. The surrounding logic answers them in the same cycle with the source samples and the accumulator inputs.

Top module: `pwm_route`

## Requirements
- R1: A control write changes only the low 4 bits of `ctrlQ` and takes them from `ctrlWdata[3:0]`. Bits 15:4 of `ctrlQ` read 0 after any write.
- R2: With mode 0x0, 0x6, 0x9 or 0xF, each output equals its accumulator input unchanged.
- R3: With mode 0x5, the left output is accInL plus srcL and the right output is accInR plus srcR.
- R4: With mode 0xA, the left output is accInL plus srcR and the right output is accInR plus srcL.
- R5: In every other mode (mono), the single routed sample is srcR when mode bits [2:1] are not both zero, and srcL otherwise.
- R6: In mono modes, the routed sample is added to the left output only when mode bits [1:0] are nonzero. It is added to the right output only when mode bits [3:2] are nonzero. An output that gets no sample equals its accumulator input.
- R7: While outputs are valid, `step` equals floor(srcCount × 65536 / outCount) for the counts captured at start, and it stays constant through the run.
- R8: The output with slot number k has `outIdx` equal to k and `rdIdx` equal to floor(k × step / 65536), counting k from 0.
- R9: A run emits exactly outCount valid outputs on consecutive cycles, and then `busy` drops. A start with outCount equal to 0 is ignored, so `busy` and `outValid` stay low.
- R10: While `silent` is high, both outputs equal their accumulator inputs whatever the mode.
- R11: Each addition treats the sample and the accumulator input as signed and clamps the result to the signed 32-bit range [-2^31, 2^31-1].
- R12: After reset, `busy` is 0, `outValid` is 0 and `ctrlQ` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWr | input | 1 | Control register write strobe |
| ctrlWdata | input | 16 | Control write data; only bits 3:0 are kept |
| ctrlQ | output | 16 | Control register value; bits 3:0 hold the mode |
| start | input | 1 | Begin a run; ignored while busy |
| silent | input | 1 | Forces zero contribution |
| srcCount | input | 16 | Source sample count for the run |
| outCount | input | 16 | Output sample count for the run |
| busy | output | 1 | Run in progress (divide or output phase) |
| step | output | 32 | 16.16 step per output sample |
| rdIdx | output | 16 | Source read pointer |
| srcL | input | 16 | Signed left source sample at rdIdx |
| srcR | input | 16 | Signed right source sample at rdIdx |
| outValid | output | 1 | Output sample valid this cycle |
| outIdx | output | 16 | Output slot number of the current sample |
| accInL | input | 32 | Signed left accumulator input for outIdx |
| accInR | input | 32 | Signed right accumulator input for outIdx |
| accOutL | output | 32 | Signed left accumulated result |
| accOutR | output | 32 | Signed right accumulated result |

## Verification
The bench builds the block with its default parameters: 16-bit samples and counts, a 32-bit accumulator and a 16-bit fraction. With these, an output length of 1 pushes the step up to 2^24. Equal or mismatched lengths cover read pointers that repeat, walk one by one or skip source samples. All sixteen mode codes are run, including every invalid and mono code. Accumulator inputs placed next to both ends of the 32-bit range drive the saturation from both sides.

// File: rtl/pwm_route_pkg.sv
package pwm_route_pkg;
  typedef struct packed {
    logic loadDiv;   // capture counts, clear divider and phase
    logic divStep;   // one restoring-division iteration
    logic advance;   // emit one output and move the phase on
  } ctrlStrobe_t;
endpackage

// File: rtl/pwm_route_ctrl.sv
module pwm_route_ctrl
  import pwm_route_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] outCount,
  output ctrlStrobe_t      strobe,
  output logic             busy,
  output logic             outValid,
  output logic [CNT_W-1:0] outIdx
);
  localparam int DIV_N = CNT_W + FRAC_W;
  localparam int DCNT_W = $clog2(DIV_N);

  typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_RUN} state_t;
  state_t state;
  logic [DCNT_W-1:0] divCnt;
  logic [CNT_W-1:0] lastIdx;
  logic launch;

  assign launch = (state == ST_IDLE) && start && (outCount != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      outIdx  <= '0;
      lastIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (launch) begin
          state   <= ST_DIV;
          divCnt  <= '0;
          lastIdx <= outCount - 1'b1;
        end
        ST_DIV: begin
          divCnt <= divCnt + 1'b1;
          if (divCnt == DCNT_W'(DIV_N - 1)) begin
            state  <= ST_RUN;
            outIdx <= '0;
          end
        end
        ST_RUN: begin
          if (outIdx == lastIdx) state <= ST_IDLE;
          else outIdx <= outIdx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.loadDiv = launch;
    strobe.divStep = (state == ST_DIV);
    strobe.advance = (state == ST_RUN);
  end

  assign busy     = (state != ST_IDLE);
  assign outValid = (state == ST_RUN);
endmodule

// File: rtl/pwm_route_satadd.sv
module pwm_route_satadd #(
  parameter int SAMP_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic [ACC_W-1:0]  acc,
  input  logic [SAMP_W-1:0] samp,
  input  logic              en,
  output logic [ACC_W-1:0]  result
);
  logic [ACC_W:0] sum;
  always_comb begin
    sum = {acc[ACC_W-1], acc} + {{(ACC_W + 1 - SAMP_W){samp[SAMP_W-1]}}, samp};
    if (!en) result = acc;
    else if (sum[ACC_W] != sum[ACC_W-1])
      result = sum[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
    else result = sum[ACC_W-1:0];
  end
endmodule

// File: rtl/pwm_route_dp.sv
module pwm_route_dp
  import pwm_route_pkg::*;
#(
  parameter int SAMP_W = 16,
  parameter int ACC_W  = 32,
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 16,
  parameter int PTR_W  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              strobe,
  input  logic [CNT_W-1:0]         srcCount,
  input  logic [CNT_W-1:0]         outCount,
  input  logic [3:0]               mode,
  input  logic                     silent,
  input  logic [SAMP_W-1:0]        srcL,
  input  logic [SAMP_W-1:0]        srcR,
  input  logic [ACC_W-1:0]         accInL,
  input  logic [ACC_W-1:0]         accInR,
  output logic [CNT_W+FRAC_W-1:0]  step,
  output logic [PTR_W-1:0]         rdIdx,
  output logic [ACC_W-1:0]         accOutL,
  output logic [ACC_W-1:0]         accOutR
);
  localparam int DIV_N = CNT_W + FRAC_W;

  logic [DIV_N-1:0]  quo;
  logic [CNT_W-1:0]  rem, divisor;
  logic [FRAC_W-1:0] phase;
  logic [CNT_W:0]    remShift, remSub;
  logic              take;
  logic [DIV_N:0]    phaseSum;

  always_comb begin
    remShift = {rem, quo[DIV_N-1]};
    take     = remShift >= {1'b0, divisor};
    remSub   = remShift - {1'b0, divisor};
    phaseSum = {{(DIV_N + 1 - FRAC_W){1'b0}}, phase} + {1'b0, quo};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quo <= '0; rem <= '0; divisor <= '0; phase <= '0; rdIdx <= '0;
    end else if (strobe.loadDiv) begin
      quo     <= {srcCount, {FRAC_W{1'b0}}};
      rem     <= '0;
      divisor <= outCount;
      phase   <= '0;
      rdIdx   <= '0;
    end else if (strobe.divStep) begin
      rem <= take ? remSub[CNT_W-1:0] : remShift[CNT_W-1:0];
      quo <= {quo[DIV_N-2:0], take};
    end else if (strobe.advance) begin
      rdIdx <= rdIdx + PTR_W'(phaseSum[DIV_N:FRAC_W]);
      phase <= phaseSum[FRAC_W-1:0];
    end
  end

  assign step = quo;

  // routing
  logic modeBad, enL, enR;
  logic [SAMP_W-1:0] pickL, pickR, monoSamp;
  assign modeBad = (mode == 4'h0) || (mode == 4'h6) || (mode == 4'h9) || (mode == 4'hF);
  assign monoSamp = (|mode[2:1]) ? srcR : srcL;

  always_comb begin
    enL = 1'b0; enR = 1'b0; pickL = srcL; pickR = srcR;
    if (!(silent || modeBad)) begin
      case (mode)
        4'h5: begin enL = 1'b1; enR = 1'b1; end
        4'hA: begin enL = 1'b1; enR = 1'b1; pickL = srcR; pickR = srcL; end
        default: begin
          pickL = monoSamp; pickR = monoSamp;
          enL = |mode[1:0]; enR = |mode[3:2];
        end
      endcase
    end
  end

  logic [1:0][ACC_W-1:0]  chAcc, chRes;
  logic [1:0][SAMP_W-1:0] chSamp;
  logic [1:0]             chEn;
  assign chAcc  = {accInR, accInL};
  assign chSamp = {pickR, pickL};
  assign chEn   = {enR, enL};

  for (genvar c = 0; c < 2; c++) begin : gCh
    pwm_route_satadd #(.SAMP_W(SAMP_W), .ACC_W(ACC_W)) uAdd (
      .acc(chAcc[c]), .samp(chSamp[c]), .en(chEn[c]), .result(chRes[c])
    );
  end

  assign accOutL = chRes[0];
  assign accOutR = chRes[1];
endmodule

// File: rtl/pwm_route.sv
module pwm_route
  import pwm_route_pkg::*;
#(
  parameter int SAMP_W = 16,
  parameter int ACC_W  = 32,
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 16,
  parameter int PTR_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ctrlWr,
  input  logic [15:0]             ctrlWdata,
  output logic [15:0]             ctrlQ,
  input  logic                    start,
  input  logic                    silent,
  input  logic [CNT_W-1:0]        srcCount,
  input  logic [CNT_W-1:0]        outCount,
  output logic                    busy,
  output logic [CNT_W+FRAC_W-1:0] step,
  output logic [PTR_W-1:0]        rdIdx,
  input  logic [SAMP_W-1:0]       srcL,
  input  logic [SAMP_W-1:0]       srcR,
  output logic                    outValid,
  output logic [CNT_W-1:0]        outIdx,
  input  logic [ACC_W-1:0]        accInL,
  input  logic [ACC_W-1:0]        accInR,
  output logic [ACC_W-1:0]        accOutL,
  output logic [ACC_W-1:0]        accOutR
);
  logic [3:0] modeReg;
  logic unusedUpper;
  ctrlStrobe_t strobe;

  assign unusedUpper = ^ctrlWdata[15:4];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeReg <= '0;
    else if (ctrlWr) modeReg <= ctrlWdata[3:0];
  end
  assign ctrlQ = {12'h000, modeReg};

  pwm_route_ctrl #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .outCount(outCount),
    .strobe(strobe), .busy(busy), .outValid(outValid), .outIdx(outIdx)
  );

  pwm_route_dp #(.SAMP_W(SAMP_W), .ACC_W(ACC_W), .CNT_W(CNT_W),
                 .FRAC_W(FRAC_W), .PTR_W(PTR_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcCount(srcCount),
    .outCount(outCount), .mode(modeReg), .silent(silent), .srcL(srcL),
    .srcR(srcR), .accInL(accInL), .accInR(accInR), .step(step),
    .rdIdx(rdIdx), .accOutL(accOutL), .accOutR(accOutR)
  );
endmodule

// File: rtl/pwm_route_chk.sv
module pwm_route_chk #(
  parameter int SAMP_W = 16,
  parameter int ACC_W  = 32,
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 16,
  parameter int PTR_W  = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    ctrlWr,
  input logic [15:0]             ctrlWdata,
  input logic [15:0]             ctrlQ,
  input logic                    start,
  input logic                    silent,
  input logic [CNT_W-1:0]        srcCount,
  input logic [CNT_W-1:0]        outCount,
  input logic                    busy,
  input logic [CNT_W+FRAC_W-1:0] step,
  input logic [PTR_W-1:0]        rdIdx,
  input logic [SAMP_W-1:0]       srcL,
  input logic [SAMP_W-1:0]       srcR,
  input logic                    outValid,
  input logic [CNT_W-1:0]        outIdx,
  input logic [ACC_W-1:0]        accInL,
  input logic [ACC_W-1:0]        accInR,
  input logic [ACC_W-1:0]        accOutL,
  input logic [ACC_W-1:0]        accOutR
);
  logic unusedChk;
  assign unusedChk = ^{ctrlWdata, start, srcCount, outCount, rdIdx, srcL, srcR};

  logic modeBad, passThru, accLMax;
  assign modeBad  = (ctrlQ[3:0] == 4'h0) || (ctrlQ[3:0] == 4'h6) ||
                    (ctrlQ[3:0] == 4'h9) || (ctrlQ[3:0] == 4'hF);
  assign passThru = (accOutL == accInL) && (accOutR == accInR);
  assign accLMax  = (accInL == {1'b0, {(ACC_W-1){1'b1}}});

  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (ctrlQ[15:4] == 12'h000)); // R1
  AST_BAD_MODE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && modeBad) |-> passThru); // R2
  AST_SILENT_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && silent) |-> passThru); // R10
  AST_STEP_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid)) |-> $stable(step)); // R7
  AST_IDX_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid)) |-> (outIdx == $past(outIdx) + 1'b1)); // R8
  AST_FIRST_IDX: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> (outIdx == '0)); // R8
  AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> busy); // R9
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && accLMax) |-> !accOutL[ACC_W-1]); // R11
endmodule

bind pwm_route pwm_route_chk #(.SAMP_W(SAMP_W), .ACC_W(ACC_W), .CNT_W(CNT_W),
  .FRAC_W(FRAC_W), .PTR_W(PTR_W)) u_chk (.*);

// File: tb/sim_pwm_route.sv
module sim_pwm_route;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWr = 1'b0;
  logic [15:0] ctrlWdata = '0;
  logic [15:0] ctrlQ;
  logic start = 1'b0;
  logic silent = 1'b0;
  logic [15:0] srcCount = '0, outCount = '0;
  logic busy, outValid;
  logic [31:0] step;
  logic [15:0] rdIdx, outIdx;
  logic [15:0] srcL, srcR;
  logic [31:0] accInL, accInR, accOutL, accOutR;

  logic [15:0] bufL [256];
  logic [15:0] bufR [256];
  logic [31:0] accL [256];
  logic [31:0] accR [256];

  int nChk = 0, nBad = 0;

  always #5 clk = ~clk;

  assign srcL   = bufL[rdIdx[7:0]];
  assign srcR   = bufR[rdIdx[7:0]];
  assign accInL = accL[outIdx[7:0]];
  assign accInR = accR[outIdx[7:0]];

  pwm_route u0 (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic longint satAdd(input longint a, input longint s);
    longint r = a + s;
    if (r > 64'sd2147483647) r = 64'sd2147483647;
    if (r < -64'sd2147483648) r = -64'sd2147483648;
    return r;
  endfunction

  function automatic bit isBad(input logic [3:0] m);
    return (m == 4'h0) || (m == 4'h6) || (m == 4'h9) || (m == 4'hF);
  endfunction

  function automatic string reqOf(input logic [3:0] m, input bit sil);
    if (sil) return "R10";
    if (isBad(m)) return "R2";
    if (m == 4'h5) return "R3";
    if (m == 4'hA) return "R4";
    return "R5 R6";
  endfunction

  // kind: 0 random, 1 saturation extremes
  task automatic runBlock(input logic [3:0] m, input int sN, input int oN,
                          input bit sil, input int kind);
    longint expStep, eL, eR, sl, sr, ml, mr;
    int k;
    string rq;
    for (int i = 0; i < 256; i++) begin
      if (kind == 1) begin
        bufL[i] = (i % 2 == 0) ? 16'h7FFF : 16'h8000;
        bufR[i] = (i % 2 == 0) ? 16'h8000 : 16'h7FFF;
        accL[i] = (i % 2 == 0) ? 32'h7FFF_FFF0 : 32'h8000_0010;
        accR[i] = (i % 2 == 0) ? 32'h8000_0005 : 32'h7FFF_FFFF;
      end else begin
        bufL[i] = 16'($urandom);
        bufR[i] = 16'($urandom);
        accL[i] = $urandom;
        accR[i] = $urandom;
      end
    end
    @(negedge clk);
    ctrlWr = 1'b1; ctrlWdata = {12'($urandom), m};
    @(negedge clk);
    ctrlWr = 1'b0;
    silent = sil; srcCount = 16'(sN); outCount = 16'(oN);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int w = 0; w < 60 && !outValid; w++) @(negedge clk);
    expStep = (longint'(sN) << 16) / oN;
    rq = (kind == 1) ? "R11" : reqOf(m, sil);
    k = 0;
    while (outValid) begin
      check(step == 32'(expStep), "R7", "step", step, expStep);
      check(outIdx == 16'(k), "R8", "outIdx", outIdx, k);
      check(rdIdx == 16'((longint'(k) * expStep) >> 16), "R8", "rdIdx", rdIdx,
            (longint'(k) * expStep) >> 16);
      sl = longint'($signed(bufL[(longint'(k) * expStep) >> 16]));
      sr = longint'($signed(bufR[(longint'(k) * expStep) >> 16]));
      eL = longint'($signed(accL[k])); eR = longint'($signed(accR[k]));
      if (!sil && !isBad(m)) begin
        if (m == 4'h5) begin eL = satAdd(eL, sl); eR = satAdd(eR, sr); end
        else if (m == 4'hA) begin eL = satAdd(eL, sr); eR = satAdd(eR, sl); end
        else begin
          ml = (m[2:1] != 2'b00) ? sr : sl;
          mr = ml;
          if (m[1:0] != 2'b00) eL = satAdd(eL, ml);
          if (m[3:2] != 2'b00) eR = satAdd(eR, mr);
        end
      end
      check(accOutL == 32'(eL), rq, "accOutL", accOutL, 32'(eL));
      check(accOutR == 32'(eR), rq, "accOutR", accOutR, 32'(eR));
      k++;
      @(negedge clk);
    end
    check(k == oN, "R9", "output count", k, oN);
    check(busy == 1'b0, "R9", "busy after run", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin
      bufL[i] = '0; bufR[i] = '0; accL[i] = '0; accR[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R12 reset state
    check(busy == 1'b0, "R12", "busy", busy, 0);
    check(outValid == 1'b0, "R12", "outValid", outValid, 0);
    check(ctrlQ == 16'h0, "R12", "ctrlQ", ctrlQ, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1 control write
    ctrlWr = 1'b1; ctrlWdata = 16'hFFF5;
    @(negedge clk);
    check(ctrlQ == 16'h0005, "R1", "ctrlQ", ctrlQ, 16'h0005);
    ctrlWdata = 16'hABCA;
    @(negedge clk);
    ctrlWr = 1'b0;
    check(ctrlQ == 16'h000A, "R1", "ctrlQ", ctrlQ, 16'h000A);
    // every mode code
    for (int m = 0; m < 16; m++) runBlock(4'(m), 40, 57, 1'b0, 0);
    // directed step values
    runBlock(4'h5, 3, 7, 1'b0, 0);
    runBlock(4'hA, 5, 2, 1'b0, 0);
    runBlock(4'h5, 256, 1, 1'b0, 0);
    runBlock(4'h3, 1, 256, 1'b0, 0);
    runBlock(4'hC, 200, 200, 1'b0, 0);
    // R10 silent
    runBlock(4'h5, 30, 20, 1'b1, 0);
    runBlock(4'hA, 30, 20, 1'b1, 0);
    // R11 saturation both directions
    runBlock(4'h5, 64, 64, 1'b0, 1);
    runBlock(4'hA, 64, 64, 1'b0, 1);
    runBlock(4'hD, 64, 64, 1'b0, 1);
    // R9 zero output count ignored
    @(negedge clk);
    srcCount = 16'd10; outCount = 16'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      bit sawBusy = 1'b0;
      for (int w = 0; w < 40; w++) begin
        if (busy || outValid) sawBusy = 1'b1;
        @(negedge clk);
      end
      check(sawBusy == 1'b0, "R9", "zero-length start", sawBusy, 0);
    end
    // random runs
    for (int r = 0; r < 14; r++)
      runBlock(4'($urandom), 1 + int'($urandom % 256), 1 + int'($urandom % 256),
               1'($urandom % 5 == 0), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule